// File: doc/BRIEF.md
# Thermal Alert Hysteresis Monitor

This block turns a stream of 8-bit temperature-sense codes into two thermal flags: an early-warning alert and a hot indication. The sense codes come from a converter that serves several channels in turn, so a fresh temperature code appears only now and then, marked by a one-cycle valid strobe. The block reads the code only in a cycle where that strobe is high.

The thermistor divider is wired so that its voltage drops as the temperature climbs. A flag therefore turns on when the code falls to its "on" threshold or below. It turns off only when the code climbs back to a higher "off" threshold or above. A code that lies strictly between the two thresholds leaves the flag as it was. Each flag has its own pair of thresholds. Both pairs are set as millivolt parameters, which are converted to codes at elaboration over a 0 to 2000 mV full scale. The conversion rounds to the nearest code, with 2000/256 mV per LSB.

The alert flag drives the port active high. The hot flag drives the port active low, so that it can feed an open-drain pad directly.

Top module: `thermal_alert_mon`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `alert` is 0 and `hot_n` is 1.
- R2: A valid sample with code at or below 63 (491 mV) sets `alert` to 1.
- R3: A valid sample with code at or above 66 (513 mV) clears `alert` to 0.
- R4: A valid sample with code 64 or 65 leaves `alert` unchanged.
- R5: A valid sample with code at or below 60 (472 mV) drives `hot_n` to 0.
- R6: A valid sample with code at or above 63 (494 mV) returns `hot_n` to 1.
- R7: A valid sample with code 61 or 62 leaves `hot_n` unchanged.
- R8: When `smp_vld` is 0, the value on `smp_code` has no effect on either output.
- R9: A valid sample changes the outputs at the first rising clock edge at which `smp_vld` is high. The outputs do not change before that edge.
- R10: Each threshold code equals round(mV × 256 / 2000). With the default parameters this gives 63/66 for the alert flag and 60/63 for the hot flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | One-cycle strobe marking a fresh temperature code |
| smp_code | input | 8 | Temperature-sense code; a lower code means hotter |
| alert | output | 1 | Early thermal alert, active high |
| hot_n | output | 1 | Over-temperature indication, active low |

## Verification
Each flag keeps one bit of state. If that bit is wrong, the error shows on `alert` or `hot_n` from the edge after the faulty update, and it stays wrong until a sample lands outside the hysteresis band. Because of this, the bench sends in-band codes after every transition: a stuck or wrongly set flag then persists where a correct one would hold. Codes are also driven with the strobe low, which would expose an update that ignores the strobe. The outputs are checked both just before and just after the strobed edge, so an extra register or a combinational path shows up as a one-cycle timing error.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;

    // Next-state record of one hysteresis flag.
    typedef struct packed {
        logic active;
    } flag_state_t;

    // Millivolt level to the nearest converter code.
    function automatic int mv_to_code(input int mv, input int full_mv, input int code_w);
        int steps;
        steps = 1 << code_w;
        return (mv * steps * 2 + full_mv) / (2 * full_mv);
    endfunction

endpackage

// File: rtl/thermal_window_cmp.sv
module thermal_window_cmp #(
    parameter int CODE_W   = 8,
    parameter int SET_CODE = 63,
    parameter int CLR_CODE = 66
) (
    input  logic [CODE_W-1:0] code,
    output logic              at_or_below_set,
    output logic              at_or_above_clr
);
    localparam logic [CODE_W-1:0] SET_V = CODE_W'(SET_CODE);
    localparam logic [CODE_W-1:0] CLR_V = CODE_W'(CLR_CODE);

    always_comb begin
        at_or_below_set = (code <= SET_V);
        at_or_above_clr = (code >= CLR_V);
    end
endmodule

// File: rtl/thermal_hyst_flag.sv
module thermal_hyst_flag
    import thermal_alert_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int SET_CODE = 63,
    parameter int CLR_CODE = 66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] smp_code,
    output logic              flag
);
    logic        hit_set;
    logic        hit_clr;
    flag_state_t st_d, st_q;

    thermal_window_cmp #(
        .CODE_W  (CODE_W),
        .SET_CODE(SET_CODE),
        .CLR_CODE(CLR_CODE)
    ) u_cmp (
        .code           (smp_code),
        .at_or_below_set(hit_set),
        .at_or_above_clr(hit_clr)
    );

    always_comb begin
        st_d = st_q;
        if (smp_vld) begin
            if (hit_set) begin
                st_d.active = 1'b1;
            end else if (hit_clr) begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.active;
endmodule

// File: rtl/thermal_alert_mon.sv
module thermal_alert_mon
    import thermal_alert_pkg::*;
#(
    parameter int CODE_W       = 8,
    parameter int FULL_MV      = 2000,
    parameter int ALERT_SET_MV = 491,
    parameter int ALERT_CLR_MV = 513,
    parameter int HOT_SET_MV   = 472,
    parameter int HOT_CLR_MV   = 494
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] smp_code,
    output logic              alert,
    output logic              hot_n
);
    // R10: thresholds rounded to the nearest code
    localparam int ALERT_SET_CODE = mv_to_code(ALERT_SET_MV, FULL_MV, CODE_W);
    localparam int ALERT_CLR_CODE = mv_to_code(ALERT_CLR_MV, FULL_MV, CODE_W);
    localparam int HOT_SET_CODE   = mv_to_code(HOT_SET_MV,   FULL_MV, CODE_W);
    localparam int HOT_CLR_CODE   = mv_to_code(HOT_CLR_MV,   FULL_MV, CODE_W);
    localparam int NUM_FLAGS      = 2;

    localparam int SET_TBL [NUM_FLAGS] = '{ALERT_SET_CODE, HOT_SET_CODE};
    localparam int CLR_TBL [NUM_FLAGS] = '{ALERT_CLR_CODE, HOT_CLR_CODE};

    logic [NUM_FLAGS-1:0] flags;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        thermal_hyst_flag #(
            .CODE_W  (CODE_W),
            .SET_CODE(SET_TBL[g]),
            .CLR_CODE(CLR_TBL[g])
        ) u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_vld (smp_vld),
            .smp_code(smp_code),
            .flag    (flags[g])
        );
    end

    assign alert = flags[0];
    assign hot_n = ~flags[1];
endmodule

// File: rtl/thermal_alert_chk.sv
module thermal_alert_chk #(
    parameter int CODE_W    = 8,
    parameter int ALERT_SET = 63,
    parameter int ALERT_CLR = 66,
    parameter int HOT_SET   = 60,
    parameter int HOT_CLR   = 63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic [CODE_W-1:0] smp_code,
    input logic              alert,
    input logic              hot_n
);
    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=> (!alert && hot_n));

    // R2
    alert_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && (int'(smp_code) <= ALERT_SET)) |=> alert);

    // R3
    alert_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && (int'(smp_code) >= ALERT_CLR)) |=> !alert);

    // R4
    alert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && (int'(smp_code) > ALERT_SET) && (int'(smp_code) < ALERT_CLR)) |=> $stable(alert));

    // R5
    hot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && (int'(smp_code) <= HOT_SET)) |=> !hot_n);

    // R6
    hot_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && (int'(smp_code) >= HOT_CLR)) |=> hot_n);

    // R7
    hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && (int'(smp_code) > HOT_SET) && (int'(smp_code) < HOT_CLR)) |=> $stable(hot_n));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(alert) && $stable(hot_n)));
endmodule

bind thermal_alert_mon thermal_alert_chk #(
    .CODE_W   (CODE_W),
    .ALERT_SET(ALERT_SET_CODE),
    .ALERT_CLR(ALERT_CLR_CODE),
    .HOT_SET  (HOT_SET_CODE),
    .HOT_CLR  (HOT_CLR_CODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .smp_code(smp_code),
    .alert   (alert),
    .hot_n   (hot_n)
);

// File: tb/tb_thermal_alert_mon.sv
module tb_thermal_alert_mon;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [7:0] smp_code = 8'd128;
    logic       alert;
    logic       hot_n;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    thermal_alert_mon dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
        .alert(alert), .hot_n(hot_n)
    );

    // Expected thresholds from mV by rounding (R10): alert 63/66, hot 60/63.
    // Row: {vld, code, exp_alert, exp_hot_n, req}
    typedef struct packed {
        logic       vld;
        logic [7:0] code;
        logic       ea;
        logic       eh;
        logic [7:0] req;
    } vec_t;
    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{1'b1, 8'd100, 1'b0, 1'b1, 8'd3},  // R3 cool code
        '{1'b1, 8'd66,  1'b0, 1'b1, 8'd3},  // R3 release boundary, R10
        '{1'b1, 8'd64,  1'b0, 1'b1, 8'd4},  // R4 in band, stays off
        '{1'b1, 8'd63,  1'b1, 1'b1, 8'd2},  // R2 set boundary, R6 hot release boundary
        '{1'b1, 8'd65,  1'b1, 1'b1, 8'd4},  // R4 in band, stays on
        '{1'b1, 8'd61,  1'b1, 1'b1, 8'd7},  // R7 hot band, stays off
        '{1'b1, 8'd60,  1'b1, 1'b0, 8'd5},  // R5 set boundary
        '{1'b0, 8'd200, 1'b1, 1'b0, 8'd8},  // R8 strobe low
        '{1'b1, 8'd62,  1'b1, 1'b0, 8'd7},  // R7 hot band, stays on
        '{1'b1, 8'd61,  1'b1, 1'b0, 8'd7},  // R7
        '{1'b1, 8'd63,  1'b1, 1'b1, 8'd6},  // R6 release boundary
        '{1'b1, 8'd65,  1'b1, 1'b1, 8'd4},  // R4
        '{1'b1, 8'd66,  1'b0, 1'b1, 8'd3},  // R3
        '{1'b1, 8'd0,   1'b1, 1'b0, 8'd2},  // R2 R5 extreme hot
        '{1'b0, 8'd255, 1'b1, 1'b0, 8'd8},  // R8
        '{1'b1, 8'd255, 1'b0, 1'b1, 8'd3},  // R3 R6 extreme cool
        '{1'b1, 8'd60,  1'b1, 1'b0, 8'd5},  // R5
        '{1'b1, 8'd64,  1'b1, 1'b1, 8'd6}   // R6 with R4 alert hold
    };

    task automatic check(input string req, input logic ea, input logic eh);
        n_chk++;
        if (alert !== ea || hot_n !== eh) begin
            n_bad++;
            $display("FAIL %s: alert=%b hot_n=%b expected alert=%b hot_n=%b",
                     req, alert, hot_n, ea, eh);
        end
    endtask

    task automatic apply(input logic v, input logic [7:0] c);
        @(negedge clk);
        smp_vld  = v;
        smp_code = c;
        @(posedge clk);
        #1;
        smp_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1 check("R1 after release", 1'b0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VT[i].vld, VT[i].code);
            check($sformatf("R%0d row %0d", VT[i].req, i), VT[i].ea, VT[i].eh);
        end

        // R9: no change before the strobed edge, change right after it
        apply(1'b1, 8'd90);
        check("R9 clear", 1'b0, 1'b1);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_code = 8'd10;
        #1 check("R9 before edge", 1'b0, 1'b1);
        @(posedge clk);
        #1 check("R9 after edge", 1'b1, 1'b0);
        smp_vld = 1'b0;

        // R1: reset mid-run clears both flags
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1 async reset", 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1 check("R1 after second reset", 1'b0, 1'b1);

        // R8: many idle hot codes do nothing
        for (int k = 0; k < 5; k++) begin
            apply(1'b0, 8'(k * 12));
        end
        check("R8 idle burst", 1'b0, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule